// File: doc/BRIEF.md
# Bus Bridge Target Disconnect Controller

This block is the target side of a slave-only bridge. A master runs read and write data phases through a simplified PCI-style target handshake. The controller forwards each phase to a local bus whose latency cannot be known in advance. It keeps one local access entry. The master side is governed by phase timers: a first phase that runs too long ends with Retry, and any later phase of a burst ends with a disconnect without data once its wait limit runs out.

A local access that has been started always runs to completion, even after the master has been turned away. Its result stays in the entry until the master repeats the same request, which is then completed at once from the entry. Addresses decoded as prefetchable may have their stale result dropped, either by a discard timer or when a different request arrives. Results from other addresses are kept until the matching repeat arrives, because reading them again would repeat a side effect.

A master phase is held on `m_valid` until a non-zero `t_resp` is seen, and is then withdrawn. The local side keeps `l_req` and its fields steady until a one-cycle `l_done`.

Top module: `bridge_disc_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `t_resp` is 0 (none) and `l_req` is low.
- R2: A request accepted with the entry free raises `l_req` on the next cycle, carrying the request's address, write flag, byte enables and write data. A local access only ever starts from an accepted master request.
- R3: When `l_done` arrives no later than the phase limit, `t_resp` becomes 1 (ack) one cycle after `l_done`. For a read, `t_rdata` then equals `l_rdata`. The entry is freed, so an identical next request starts a new local access.
- R4: A phase with `m_first` low that gets no `l_done` shows `t_resp` = 3 (disconnect without data) exactly NEXT_LIMIT clock edges after the edge that accepted it.
- R5: A phase with `m_first` high that gets no `l_done` shows `t_resp` = 2 (retry) exactly FIRST_LIMIT edges after the edge that accepted it.
- R6: After a retry or disconnect, `l_req` and its fields stay steady until `l_done`. After that the access is finished and `l_req` falls.
- R7: A request whose address, write flag and byte enables equal those of a completed, held entry is answered with ack on the next cycle. For a read the held data is returned. No new local access starts, and the entry is freed.
- R8: Any request that arrives while the local access is still pending, whether or not it matches, is answered with retry on the next cycle, and no new local access starts.
- R9: A held entry at an address outside the prefetchable region is never dropped. Non-matching requests get retry however long the wait, and the matching repeat still gets the held data.
- R10: Prefetchable means `(addr & PREF_MASK) == PREF_MATCH`; the default is address bit 31 set. A held prefetchable entry is dropped when a non-matching request arrives, and that request starts its own local access.
- R11: A held prefetchable entry is dropped after DISCARD_CYCLES clocks without a matching repeat. A later repeat then starts a fresh local access.
- R12: A write is acknowledged only after its local write has completed. A slow first write phase ends with retry. Its matching repeat after completion is acknowledged without a second local write.
- R13: `t_resp` is non-zero for exactly one cycle per phase, and no request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Master data phase present |
| m_first | input | 1 | Phase is the first of its burst |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | ADDR_W | Phase address |
| m_be | input | DATA_W/8 | Byte enables |
| m_wdata | input | DATA_W | Write data |
| t_resp | output | 2 | 0 none, 1 ack, 2 retry, 3 disconnect without data |
| t_rdata | output | DATA_W | Read data, valid with ack |
| l_req | output | 1 | Local access in progress |
| l_write | output | 1 | Local access is a write |
| l_addr | output | ADDR_W | Local address |
| l_be | output | DATA_W/8 | Local byte enables |
| l_wdata | output | DATA_W | Local write data |
| l_done | input | 1 | Local access completes this cycle |
| l_rdata | input | DATA_W | Local read data, valid with `l_done` |

## Verification
The bench builds the block with 32-bit address and data, FIRST_LIMIT 16 and NEXT_LIMIT 8. It shortens DISCARD_CYCLES from 32768 to 64, so that both sides of the discard rule fit in a short run: a prefetchable entry expiring, and a non-prefetchable entry surviving more than three times that span. A local responder with adjustable latency and a stall switch puts completion on either side of each phase limit, so each limit is checked at its exact edge.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_RETRY = 2'd2,
        RSP_DISC  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ENT_EMPTY = 2'd0,
        ENT_BUSY  = 2'd1,
        ENT_HELD  = 2'd2
    } ent_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } ph_e;
endpackage

// File: rtl/bdc_tag_match.sv
// Compares a master request with the held entry and decodes the prefetchable region.
module bdc_tag_match #(
    parameter int              ADDR_W     = 32,
    parameter int              BE_W       = 4,
    parameter logic [ADDR_W-1:0] PREF_MASK  = '0,
    parameter logic [ADDR_W-1:0] PREF_MATCH = '0
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [BE_W-1:0]   req_be,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic              ent_write,
    input  logic [BE_W-1:0]   ent_be,
    output logic              same_tag,
    output logic              req_pref
);
    always_comb begin
        same_tag = (req_addr == ent_addr) && (req_write == ent_write) && (req_be == ent_be);
        req_pref = ((req_addr & PREF_MASK) == PREF_MATCH);
    end
endmodule

// File: rtl/bdc_phase_timer.sv
// Counts wait clocks of the current data phase against the limit chosen at its start.
module bdc_phase_timer #(
    parameter int FIRST_LIMIT = 16,
    parameter int NEXT_LIMIT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic first,
    input  logic run,
    output logic expired
);
    localparam int MAX_L = (FIRST_LIMIT > NEXT_LIMIT) ? FIRST_LIMIT : NEXT_LIMIT;
    localparam int CW    = $clog2(MAX_L + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    assign expired = (tmr_q.cnt == tmr_q.lim);

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = CW'(1);
            tmr_d.lim = first ? CW'(FIRST_LIMIT) : CW'(NEXT_LIMIT);
        end else if (run && !expired) begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt <= '0;
            tmr_q.lim <= CW'(NEXT_LIMIT);
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/bdc_hold_entry.sv
// Single local access entry: drives the local bus while busy, keeps the result afterwards.
module bdc_hold_entry
    import bdc_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int BE_W           = 4,
    parameter int DISCARD_CYCLES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_write,
    input  logic [BE_W-1:0]   a_be,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_pref,
    input  logic              take,
    input  logic              l_done,
    input  logic [DATA_W-1:0] l_rdata,
    output ent_e              state,
    output logic [ADDR_W-1:0] e_addr,
    output logic              e_write,
    output logic [BE_W-1:0]   e_be,
    output logic              e_pref,
    output logic [DATA_W-1:0] e_data
);
    localparam int DCW = (DISCARD_CYCLES > 2) ? $clog2(DISCARD_CYCLES) : 1;
    localparam logic [DCW-1:0] DC_LAST = DCW'(DISCARD_CYCLES - 1);

    typedef struct packed {
        ent_e              st;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [BE_W-1:0]   be;
        logic              pref;
        logic [DATA_W-1:0] data;
        logic [DCW-1:0]    dcnt;
    } ent_t;

    ent_t ent_q, ent_d;

    always_comb begin
        ent_d = ent_q;
        unique case (ent_q.st)
            ENT_BUSY: begin
                if (l_done) begin
                    if (!ent_q.write) ent_d.data = l_rdata;
                    ent_d.st   = take ? ENT_EMPTY : ENT_HELD;
                    ent_d.dcnt = '0;
                end
            end
            ENT_HELD: begin
                if (take) begin
                    ent_d.st = ENT_EMPTY;
                end else if (ent_q.pref) begin
                    if (ent_q.dcnt == DC_LAST) begin
                        ent_d.st   = ENT_EMPTY;
                        ent_d.dcnt = '0;
                    end else begin
                        ent_d.dcnt = ent_q.dcnt + DCW'(1);
                    end
                end
            end
            default: ;
        endcase
        if (alloc) begin
            ent_d.st    = ENT_BUSY;
            ent_d.addr  = a_addr;
            ent_d.write = a_write;
            ent_d.be    = a_be;
            ent_d.pref  = a_pref;
            ent_d.data  = a_wdata;
            ent_d.dcnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q       <= '0;
            ent_q.st    <= ENT_EMPTY;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign state   = ent_q.st;
    assign e_addr  = ent_q.addr;
    assign e_write = ent_q.write;
    assign e_be    = ent_q.be;
    assign e_pref  = ent_q.pref;
    assign e_data  = ent_q.data;
endmodule

// File: rtl/bridge_disc_ctrl.sv
// Phase controller: accepts master phases, answers ack / retry / disconnect.
module bridge_disc_ctrl
    import bdc_pkg::*;
#(
    parameter int                ADDR_W         = 32,
    parameter int                DATA_W         = 32,
    parameter int                FIRST_LIMIT    = 16,
    parameter int                NEXT_LIMIT     = 8,
    parameter int                DISCARD_CYCLES = 32768,
    parameter logic [ADDR_W-1:0] PREF_MASK      = ADDR_W'(1) << (ADDR_W - 1),
    parameter logic [ADDR_W-1:0] PREF_MATCH     = ADDR_W'(1) << (ADDR_W - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_valid,
    input  logic                m_first,
    input  logic                m_write,
    input  logic [ADDR_W-1:0]   m_addr,
    input  logic [DATA_W/8-1:0] m_be,
    input  logic [DATA_W-1:0]   m_wdata,
    output logic [1:0]          t_resp,
    output logic [DATA_W-1:0]   t_rdata,
    output logic                l_req,
    output logic                l_write,
    output logic [ADDR_W-1:0]   l_addr,
    output logic [DATA_W/8-1:0] l_be,
    output logic [DATA_W-1:0]   l_wdata,
    input  logic                l_done,
    input  logic [DATA_W-1:0]   l_rdata
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        ph_e               ph;
        rsp_e              rsp;
        logic              first;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    ent_e              ent_st;
    logic [ADDR_W-1:0] ent_addr;
    logic              ent_write;
    logic [BE_W-1:0]   ent_be;
    logic              ent_pref;
    logic [DATA_W-1:0] ent_data;
    logic              ent_alloc;
    logic              ent_take;
    logic              same_tag;
    logic              req_pref;
    logic              tmr_start;
    logic              tmr_expired;

    bdc_tag_match #(
        .ADDR_W     (ADDR_W),
        .BE_W       (BE_W),
        .PREF_MASK  (PREF_MASK),
        .PREF_MATCH (PREF_MATCH)
    ) u_match (
        .req_addr  (m_addr),
        .req_write (m_write),
        .req_be    (m_be),
        .ent_addr  (ent_addr),
        .ent_write (ent_write),
        .ent_be    (ent_be),
        .same_tag  (same_tag),
        .req_pref  (req_pref)
    );

    bdc_phase_timer #(
        .FIRST_LIMIT (FIRST_LIMIT),
        .NEXT_LIMIT  (NEXT_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .first   (m_first),
        .run     (ctl_q.ph == PH_WAIT),
        .expired (tmr_expired)
    );

    bdc_hold_entry #(
        .ADDR_W         (ADDR_W),
        .DATA_W         (DATA_W),
        .BE_W           (BE_W),
        .DISCARD_CYCLES (DISCARD_CYCLES)
    ) u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc   (ent_alloc),
        .a_addr  (m_addr),
        .a_write (m_write),
        .a_be    (m_be),
        .a_wdata (m_wdata),
        .a_pref  (req_pref),
        .take    (ent_take),
        .l_done  (l_done),
        .l_rdata (l_rdata),
        .state   (ent_st),
        .e_addr  (ent_addr),
        .e_write (ent_write),
        .e_be    (ent_be),
        .e_pref  (ent_pref),
        .e_data  (ent_data)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rsp = RSP_NONE;
        ent_alloc = 1'b0;
        ent_take  = 1'b0;
        tmr_start = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (m_valid && (ctl_q.rsp == RSP_NONE)) begin
                    if ((ent_st == ENT_HELD) && same_tag) begin
                        ctl_d.rsp   = RSP_ACK;
                        ctl_d.rdata = ent_data;
                        ent_take    = 1'b1;
                    end else if ((ent_st == ENT_EMPTY) ||
                                 ((ent_st == ENT_HELD) && ent_pref)) begin
                        ent_alloc   = 1'b1;
                        tmr_start   = 1'b1;
                        ctl_d.first = m_first;
                        ctl_d.ph    = PH_WAIT;
                    end else begin
                        ctl_d.rsp   = RSP_RETRY;
                    end
                end
            end
            PH_WAIT: begin
                if (l_done && (ent_st == ENT_BUSY)) begin
                    ctl_d.rsp   = RSP_ACK;
                    ctl_d.rdata = ent_write ? ent_data : l_rdata;
                    ent_take    = 1'b1;
                    ctl_d.ph    = PH_IDLE;
                end else if (tmr_expired) begin
                    ctl_d.rsp   = ctl_q.first ? RSP_RETRY : RSP_DISC;
                    ctl_d.ph    = PH_IDLE;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.ph    <= PH_IDLE;
            ctl_q.rsp   <= RSP_NONE;
            ctl_q.first <= 1'b0;
            ctl_q.rdata <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign t_resp  = ctl_q.rsp;
    assign t_rdata = ctl_q.rdata;
    assign l_req   = (ent_st == ENT_BUSY);
    assign l_write = ent_write;
    assign l_addr  = ent_addr;
    assign l_be    = ent_be;
    assign l_wdata = ent_data;
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
    parameter int ADDR_W     = 32,
    parameter int NEXT_LIMIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_first,
    input logic [1:0]        t_resp,
    input logic              l_req,
    input logic              l_done,
    input logic              l_write,
    input logic [ADDR_W-1:0] l_addr,
    input logic [1:0]        ent_st,
    input logic              ent_pref,
    input logic              ent_take
);
    int wait_edges;

    always_ff @(posedge clk) begin
        if (!rst_n || !m_valid || (t_resp != 2'd0)) wait_edges <= 0;
        else                                         wait_edges <= wait_edges + 1;
    end

    assert_resp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (t_resp != 2'd0) |=> (t_resp == 2'd0));

    assert_access_from_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_req) |-> $past(m_valid));

    assert_access_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_req && !l_done) |=> (l_req && $stable(l_addr) && $stable(l_write)));

    assert_disc_later_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_resp == 2'd3) |-> $past(!m_first));

    assert_disc_on_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_resp == 2'd3) |-> (wait_edges == NEXT_LIMIT + 1));

    assert_retry_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_resp == 2'd2) |-> !$rose(l_req));

    assert_side_effect_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ent_st == 2'd2) && !ent_pref && !ent_take) |=> (ent_st == 2'd2));
endmodule

bind bridge_disc_ctrl bdc_checker #(
    .ADDR_W     (ADDR_W),
    .NEXT_LIMIT (NEXT_LIMIT)
) u_bdc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_valid  (m_valid),
    .m_first  (m_first),
    .t_resp   (t_resp),
    .l_req    (l_req),
    .l_done   (l_done),
    .l_write  (l_write),
    .l_addr   (l_addr),
    .ent_st   (ent_st),
    .ent_pref (ent_pref),
    .ent_take (ent_take)
);

// File: tb/bridge_disc_ctrl_bench.sv
module bridge_disc_ctrl_bench;
    localparam int FL = 16;
    localparam int NL = 8;
    localparam int DC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_valid = 1'b0;
    logic        m_first = 1'b0;
    logic        m_write = 1'b0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_be = '0;
    logic [31:0] m_wdata = '0;
    logic [1:0]  t_resp;
    logic [31:0] t_rdata;
    logic        l_req;
    logic        l_write;
    logic [31:0] l_addr;
    logic [3:0]  l_be;
    logic [31:0] l_wdata;
    logic        l_done = 1'b0;
    logic [31:0] l_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc = 0;
    int lat = 1;
    bit go = 1'b1;
    int lcnt = 0;
    logic [31:0] cap_addr = '0;
    logic [31:0] cap_wdata = '0;
    logic        cap_write = 1'b0;
    logic [3:0]  cap_be = '0;

    always #5 clk = ~clk;

    bridge_disc_ctrl #(
        .ADDR_W(32), .DATA_W(32), .FIRST_LIMIT(FL), .NEXT_LIMIT(NL), .DISCARD_CYCLES(DC)
    ) u_bridge_disc_ctrl (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_first(m_first), .m_write(m_write),
        .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata), .t_resp(t_resp), .t_rdata(t_rdata),
        .l_req(l_req), .l_write(l_write), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
        .l_done(l_done), .l_rdata(l_rdata)
    );

    function automatic logic [31:0] exp_rd(input logic [31:0] a);
        return a ^ 32'h5A5A_5A5A;
    endfunction

    // Local bus model: latency counted in clocks with l_req high, stall while go is low.
    always @(negedge clk) begin
        if (!rst_n) begin
            l_done = 1'b0;
            lcnt = 0;
        end else if (l_done) begin
            l_done = 1'b0;
            lcnt = 0;
        end else if (l_req) begin
            if (lcnt == 0) begin
                acc++;
                cap_addr = l_addr;
                cap_write = l_write;
                cap_be = l_be;
                cap_wdata = l_wdata;
            end
            lcnt++;
            if (go && lcnt >= lat) begin
                l_done = 1'b1;
                l_rdata = exp_rd(l_addr);
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One master data phase; returns response, data, and edges from raise to response.
    task automatic phase(input bit first, input bit wr, input logic [31:0] a,
                         input logic [3:0] be, input logic [31:0] wd,
                         output logic [1:0] rsp, output logic [31:0] rd, output int edges);
        m_first = first; m_write = wr; m_addr = a; m_be = be; m_wdata = wd;
        m_valid = 1'b1;
        edges = 0;
        rsp = 2'd0;
        rd = '0;
        while (rsp == 2'd0 && edges < 1000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            rsp = t_resp;
            rd = t_rdata;
        end
        m_valid = 1'b0;
        chk(rsp != 2'd0, "R13", "phase got a response", 32'(rsp), 32'd1);
        @(negedge clk);
        chk(t_resp == 2'd0, "R13", "response lasts one cycle", 32'(t_resp), 32'd0);
    endtask

    task automatic t_reset();
        chk(t_resp == 2'd0, "R1", "t_resp in reset", 32'(t_resp), 32'd0);
        chk(l_req == 1'b0, "R1", "l_req in reset", 32'(l_req), 32'd0);
    endtask

    task automatic t_basic_read();
        logic [1:0] r; logic [31:0] d; int e; int a0;
        lat = 3; go = 1'b1; a0 = acc;
        phase(1'b1, 1'b0, 32'h0000_0100, 4'h3, '0, r, d, e);
        chk(r == 2'd1 && e == 4, "R3", "read ack after 3-clock latency", {r, 30'(e)}, {2'd1, 30'd4});
        chk(d == exp_rd(32'h100), "R3", "read data", d, exp_rd(32'h100));
        chk(acc == a0 + 1 && cap_addr == 32'h100 && cap_be == 4'h3 && !cap_write,
            "R2", "local access fields", cap_addr, 32'h100);
        phase(1'b1, 1'b0, 32'h0000_0100, 4'h3, '0, r, d, e);
        chk(r == 2'd1 && acc == a0 + 2, "R3", "entry freed, new access", 32'(acc), 32'(a0 + 2));
    endtask

    task automatic t_burst_disc();
        logic [1:0] r; logic [31:0] d; int e; int a0;
        lat = 2; go = 1'b1;
        phase(1'b1, 1'b0, 32'h8000_0100, 4'hF, '0, r, d, e);
        chk(r == 2'd1 && e == 3, "R3", "burst first phase ack", 32'(e), 32'd3);
        go = 1'b0;
        phase(1'b0, 1'b0, 32'h8000_0104, 4'hF, '0, r, d, e);
        chk(r == 2'd3, "R4", "later phase disconnects", 32'(r), 32'd3);
        chk(e == NL + 1, "R4", "disconnect edge", 32'(e), 32'(NL + 1));
        chk(l_req == 1'b1 && l_addr == 32'h8000_0104, "R6", "access kept after disconnect", l_addr, 32'h8000_0104);
        a0 = acc;
        go = 1'b1;
        idle(4);
        chk(l_req == 1'b0, "R6", "access finished", 32'(l_req), 32'd0);
        phase(1'b1, 1'b0, 32'h8000_0104, 4'hF, '0, r, d, e);
        chk(r == 2'd1 && e == 1, "R7", "repeat hits held read", 32'(e), 32'd1);
        chk(d == exp_rd(32'h8000_0104), "R7", "held read data", d, exp_rd(32'h8000_0104));
        chk(acc == a0, "R7", "no new access on hit", 32'(acc), 32'(a0));
    endtask

    task automatic t_pending_retry();
        logic [1:0] r; logic [31:0] d; int e; int a0;
        lat = 1; go = 1'b0;
        phase(1'b1, 1'b0, 32'h0000_0200, 4'hF, '0, r, d, e);
        chk(r == 2'd2 && e == FL + 1, "R5", "first phase retry edge", 32'(e), 32'(FL + 1));
        a0 = acc;
        phase(1'b1, 1'b0, 32'h0000_0200, 4'hF, '0, r, d, e);
        chk(r == 2'd2 && e == 1, "R8", "matching repeat while pending", 32'(r), 32'd2);
        phase(1'b1, 1'b0, 32'h0000_0204, 4'hF, '0, r, d, e);
        chk(r == 2'd2 && e == 1, "R8", "other request while pending", 32'(r), 32'd2);
        chk(acc == a0 && l_addr == 32'h200, "R8", "no access started", 32'(acc), 32'(a0));
        go = 1'b1;
        idle(3);
        phase(1'b1, 1'b0, 32'h0000_0200, 4'hF, '0, r, d, e);
        chk(r == 2'd1 && d == exp_rd(32'h200), "R7", "repeat after completion", d, exp_rd(32'h200));
    endtask

    task automatic t_nonpref_kept();
        logic [1:0] r; logic [31:0] d; int e; int a0;
        lat = 1; go = 1'b0;
        phase(1'b1, 1'b0, 32'h0000_0300, 4'hF, '0, r, d, e);
        chk(r == 2'd2, "R5", "slow side-effect read retried", 32'(r), 32'd2);
        go = 1'b1;
        idle(3 * DC + 8);
        a0 = acc;
        phase(1'b1, 1'b0, 32'h0000_0400, 4'hF, '0, r, d, e);
        chk(r == 2'd2 && acc == a0, "R9", "other request refused", 32'(r), 32'd2);
        phase(1'b1, 1'b0, 32'h0000_0300, 4'hF, '0, r, d, e);
        chk(r == 2'd1 && e == 1 && d == exp_rd(32'h300), "R9", "held data survives", d, exp_rd(32'h300));
        chk(acc == a0, "R9", "no re-read", 32'(acc), 32'(a0));
    endtask

    task automatic t_pref_discard();
        logic [1:0] r; logic [31:0] d; int e; int a0;
        lat = 1; go = 1'b0;
        phase(1'b1, 1'b0, 32'h8000_0500, 4'hF, '0, r, d, e);
        chk(r == 2'd2, "R5", "prefetchable read retried", 32'(r), 32'd2);
        go = 1'b1;
        idle(DC + 40);
        a0 = acc;
        lat = 2;
        phase(1'b1, 1'b0, 32'h8000_0500, 4'hF, '0, r, d, e);
        chk(r == 2'd1 && e == 3, "R11", "expired entry re-fetched", 32'(e), 32'd3);
        chk(acc == a0 + 1, "R11", "fresh local access", 32'(acc), 32'(a0 + 1));
    endtask

    task automatic t_pref_replace();
        logic [1:0] r; logic [31:0] d; int e; int a0;
        lat = 1; go = 1'b0;
        phase(1'b1, 1'b0, 32'h8000_0600, 4'hF, '0, r, d, e);
        go = 1'b1;
        idle(4);
        a0 = acc;
        phase(1'b1, 1'b0, 32'h0000_0700, 4'hF, '0, r, d, e);
        chk(r == 2'd1 && e == 2, "R10", "mismatch replaces prefetchable entry", 32'(e), 32'd2);
        chk(acc == a0 + 1 && cap_addr == 32'h700 && d == exp_rd(32'h700),
            "R10", "new access address", cap_addr, 32'h700);
    endtask

    task automatic t_write_posted();
        logic [1:0] r; logic [31:0] d; int e; int a0;
        lat = 20; go = 1'b1;
        phase(1'b1, 1'b1, 32'h0000_0800, 4'hF, 32'hCAFE_0001, r, d, e);
        chk(r == 2'd2 && e == FL + 1, "R12", "slow write retried", 32'(r), 32'd2);
        chk(cap_write && cap_wdata == 32'hCAFE_0001, "R2", "write posted to local bus", cap_wdata, 32'hCAFE_0001);
        idle(12);
        chk(l_req == 1'b0, "R6", "write finished on local bus", 32'(l_req), 32'd0);
        a0 = acc;
        phase(1'b1, 1'b1, 32'h0000_0800, 4'hF, 32'hCAFE_0001, r, d, e);
        chk(r == 2'd1 && e == 1 && acc == a0, "R12", "repeat acks without second write", 32'(acc), 32'(a0));
        lat = 2;
        phase(1'b1, 1'b1, 32'h0000_0900, 4'h1, 32'h0000_00AB, r, d, e);
        chk(r == 2'd1 && e == 3 && acc == a0 + 1, "R12", "fast write acked after done", 32'(e), 32'd3);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_basic_read();
        t_burst_disc();
        t_pending_retry();
        t_nonpref_kept();
        t_pref_discard();
        t_pref_replace();
        t_write_posted();
        idle(2);
        summary();
    end
endmodule